// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block serialises one parallel data word into an asynchronous line frame. The frame has a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames. A one-cycle baud-tick input sets the pace, and every bit on the line lasts a fixed number of those ticks.

A producer presents a word on a valid/ready handshake. The transmitter takes the word only while it is idle. At that moment it captures the word and the frame-shape controls: word length, stop count, parity enable, even select and stick parity. The line control can therefore change freely while a frame is on the wire. A separate break input is applied live. It pulls the line low at once and holds it there. The frame sequencer keeps running underneath, so a frame that was in flight still finishes on time.

Top module: `uart_frame_tx`

## Requirements
- R1: A synchronous active-high reset puts the block in idle, with `txd` = 1 and `in_ready` = 1, even when a frame is in flight.
- R2: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. After that edge `in_ready` is 0 until the frame ends. While the block is busy, `in_valid` and `in_data` have no effect: the frame in flight is unchanged and the ignored word is never sent.
- R3: Each frame begins with one start bit of 0, followed by `5 + cfg_wlen` data bits, least significant bit first. The `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits.
- R4: When `cfg_par_en` = 1, exactly one parity bit sits between the last data bit and the first stop bit. When `cfg_par_en` = 0, no parity slot exists and the stop bits follow the last data bit directly.
- R5: With parity on, `cfg_par_stick` = 0 and `cfg_par_even` = 0, the sent data bits plus the parity bit hold an odd number of ones.
- R6: With parity on, `cfg_par_stick` = 0 and `cfg_par_even` = 1, the sent data bits plus the parity bit hold an even number of ones.
- R7: With parity on and `cfg_par_stick` = 1, the parity bit is the inverse of `cfg_par_even`, whatever the data.
- R8: The stop field is one bit of 1 when `cfg_two_stop` = 0 and two bits of 1 when it is 1. The line is 1 while the block is idle.
- R9: Every bit lasts 16 baud ticks. `in_ready` returns to 1 on the clock edge that carries the tick numbered `16 * bits-in-frame`, counting from the accept edge, and not before.
- R10: While `cfg_break` = 1, `txd` is 0 from the next clock edge onward, whether the block is idle or busy. `txd` returns to normal output one edge after the break input clears.
- R11: Break does not stall the sequencer. A frame under break ends on the same tick count as it would without break.
- R12: Word length, stop count and parity controls are captured at the accept edge. Changes to them during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pacing pulse, 16 per bit |
| cfg_wlen | input | WL_W (2) | Word length code, bits = 5 + code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_par_en | input | 1 | 1 inserts a parity bit |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_par_stick | input | 1 | 1 fixes the parity bit to the inverse of the even select |
| cfg_break | input | 1 | 1 forces the line low |
| in_valid | input | 1 | Word offered |
| in_data | input | DATA_W (8) | Word to send |
| in_ready | output | 1 | Block idle, able to take a word |
| txd | output | 1 | Serial line, registered |

## Verification
The bench builds the block with its defaults: 8-bit data, a 5-bit minimum word length and 16 ticks per bit. At that size every combination of word length, stop count and the five parity modes can be swept. Each combination is sent with all-zero data, all-one data, a mixed fixed pattern and a random pattern, and every bit is sampled in the middle of its slot. The bench runs the ticks back to back for most frames, and spaced three clocks apart for others, so that bit timing is proven in ticks rather than in clocks. Dedicated frames place a break in mid-frame, change the controls and offer a second word while busy, and apply a reset in the middle of a frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // frame shape captured when a word is taken
  typedef struct packed {
    logic two_stop;
    logic par_en;
    logic par_even;
    logic par_stick;
  } frame_shape_t;

endpackage

// File: rtl/uart_tx_ticker.sv
module uart_tx_ticker #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic bit_done
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign bit_done = tick && !clear && (cnt == LAST);
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5,
  parameter int WL_W   = 2
) (
  input  logic [DATA_W-1:0] data,
  input  logic [WL_W-1:0]   wlen,
  input  logic              even_sel,
  input  logic              stick,
  output logic              par_bit
);
  logic [DATA_W-1:0] mask;
  logic              ones_odd;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (g < MIN_W + int'(wlen));
  end

  assign ones_odd = ^(data & mask);

  always_comb begin
    if (stick)         par_bit = ~even_sel;
    else if (even_sel) par_bit = ones_odd;
    else               par_bit = ~ones_odd;
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int MIN_W         = 5,
  parameter int TICKS_PER_BIT = 16,
  parameter int WL_W          = $clog2(DATA_W - MIN_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic [WL_W-1:0]   cfg_wlen,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              cfg_break,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state;
  frame_shape_t      shape_q;
  logic [WL_W-1:0]   wlen_q;
  logic [DATA_W-1:0] data_q;
  logic [IW-1:0]     bit_idx;
  logic [IW-1:0]     last_idx;
  logic              stop_idx;
  logic              accept;
  logic              bit_done;
  logic              par_bit;
  logic              line_bit;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign last_idx = IW'(MIN_W - 1) + IW'(wlen_q);

  uart_tx_ticker #(.TICKS(TICKS_PER_BIT)) u_ticker (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .tick     (baud_tick),
    .bit_done (bit_done)
  );

  uart_tx_parity #(.DATA_W(DATA_W), .MIN_W(MIN_W), .WL_W(WL_W)) u_parity (
    .data     (data_q),
    .wlen     (wlen_q),
    .even_sel (shape_q.par_even),
    .stick    (shape_q.par_stick),
    .par_bit  (par_bit)
  );

  // frame sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shape_q  <= '0;
      wlen_q   <= '0;
      data_q   <= '0;
      bit_idx  <= '0;
      stop_idx <= 1'b0;
    end else if (accept) begin
      state    <= ST_START;
      data_q   <= in_data;
      wlen_q   <= cfg_wlen;
      shape_q  <= '{two_stop: cfg_two_stop, par_en: cfg_par_en,
                    par_even: cfg_par_even, par_stick: cfg_par_stick};
      bit_idx  <= '0;
      stop_idx <= 1'b0;
    end else if (bit_done) begin
      unique case (state)
        ST_START: begin
          state   <= ST_DATA;
          bit_idx <= '0;
        end
        ST_DATA: begin
          if (bit_idx == last_idx) begin
            state    <= shape_q.par_en ? ST_PAR : ST_STOP;
            stop_idx <= 1'b0;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_PAR: begin
          state    <= ST_STOP;
          stop_idx <= 1'b0;
        end
        ST_STOP: begin
          if (stop_idx == shape_q.two_stop) state <= ST_IDLE;
          else                              stop_idx <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = data_q[bit_idx];
      ST_PAR:   line_bit = par_bit;
      default:  line_bit = 1'b1;
    endcase
  end

  // registered line driver with live break override
  always_ff @(posedge clk) begin
    if (rst)            txd <= 1'b1;
    else if (cfg_break) txd <= 1'b0;
    else                txd <= line_bit;
  end
endmodule

// File: rtl/uart_frame_tx_checker.sv
module uart_frame_tx_checker (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic cfg_break,
  input logic in_valid,
  input logic in_ready,
  input logic txd
);
  // R8: idle line is mark
  assert_idle_mark_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(in_ready) && !$past(cfg_break) && !$past(rst)) |-> txd);

  // R10: break holds the line at space
  assert_break_space_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_break) && !$past(rst)) |-> !txd);

  // R2: a taken word makes the block busy
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R9: a frame ends only on a baud tick
  assert_end_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_ready) && !$past(rst)) |-> $past(baud_tick));

  // R3: the start bit follows the accept edge
  assert_start_space_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && in_ready, 2) && !$past(rst) && !$past(rst, 2)
     && !$past(cfg_break)) |-> !txd);
endmodule

bind uart_frame_tx uart_frame_tx_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .baud_tick (baud_tick),
  .cfg_break (cfg_break),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .txd       (txd)
);

// File: tb/uart_frame_tx_bench.sv
`timescale 1ns/1ps
module uart_frame_tx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic [1:0] cfg_wlen = '0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_par_stick = 1'b0;
  logic       cfg_break = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       txd;

  int errors = 0;
  int checks = 0;
  int tick_period = 1;
  int phase = 0;
  int tick_cnt = 0;

  always #2 clk = ~clk;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .cfg_wlen(cfg_wlen),
    .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_par_stick(cfg_par_stick),
    .cfg_break(cfg_break), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd)
  );

  always @(negedge clk) begin
    phase = phase + 1;
    baud_tick = ((phase % tick_period) == 0);
  end

  always @(posedge clk) if (baud_tick) tick_cnt <= tick_cnt + 1;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // send one frame and check every bit in its middle
  task automatic send_frame(input logic [7:0] d, input int wl, input int ts,
                            input int pe, input int ev, input int st,
                            input int disturb, input int brk_at);
    logic [15:0] bits;
    int n, base, ones, early;
    string ptag;
    bits = '0;
    n = 0;
    bits[n] = 1'b0; n++;
    for (int i = 0; i < wl; i++) begin bits[n] = d[i]; n++; end
    ptag = "R4";
    if (pe != 0) begin
      ones = $countones(d & 8'((1 << wl) - 1));
      if (st != 0)      begin bits[n] = (ev == 0); ptag = "R7"; end
      else if (ev != 0) begin bits[n] = ((ones % 2) == 1); ptag = "R6"; end
      else              begin bits[n] = ((ones % 2) == 0); ptag = "R5"; end
      n++;
    end
    bits[n] = 1'b1; n++;
    if (ts != 0) begin bits[n] = 1'b1; n++; end

    @(negedge clk);
    check("R2", "ready before offer", in_ready, 1);
    cfg_wlen = 2'(wl - 5); cfg_two_stop = ts[0]; cfg_par_en = pe[0];
    cfg_par_even = ev[0]; cfg_par_stick = st[0];
    in_data = d; in_valid = 1'b1;
    @(posedge clk); #1;
    base = tick_cnt;
    @(negedge clk);
    in_valid = 1'b0;
    if (disturb != 0) begin
      in_valid = 1'b1; in_data = ~d;
      cfg_wlen = ~cfg_wlen; cfg_two_stop = ~cfg_two_stop;
      cfg_par_en = ~cfg_par_en; cfg_par_even = ~cfg_par_even;
      cfg_par_stick = ~cfg_par_stick;
    end
    for (int k = 0; k < n; k++) begin
      if (k == brk_at) cfg_break = 1'b1;
      while (tick_cnt - base < 16 * k + 8) begin @(posedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      if (brk_at >= 0 && k >= brk_at)
        check("R10", $sformatf("break bit %0d", k), txd, 0);
      else if (k == 0)
        check("R3", "start bit", txd, 0);
      else if (k <= wl)
        check(disturb != 0 ? "R12" : "R3", $sformatf("data bit %0d", k - 1), txd, bits[k]);
      else if (pe != 0 && k == wl + 1)
        check(ptag, "parity bit", txd, bits[k]);
      else
        check(pe == 0 ? "R4" : "R8", $sformatf("stop bit %0d", k), txd, bits[k]);
      check("R2", "busy mid frame", in_ready, 0);
    end
    if (disturb != 0) begin
      in_valid = 1'b0;
      cfg_wlen = 2'(wl - 5); cfg_two_stop = ts[0]; cfg_par_en = pe[0];
      cfg_par_even = ev[0]; cfg_par_stick = st[0];
    end
    early = 0;
    while (tick_cnt - base < 16 * n) begin
      @(posedge clk); #1;
      if (tick_cnt - base < 16 * n && in_ready) early = 1;
    end
    check("R9", "no early ready", early, 0);
    check(brk_at >= 0 ? "R11" : "R9", "ready at frame end", in_ready, 1);
    @(negedge clk);
    if (brk_at >= 0) begin
      check("R10", "break while idle", txd, 0);
      cfg_break = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R10", "break released", txd, 1);
    end else begin
      @(posedge clk);
      @(negedge clk);
      check("R8", "idle mark", txd, 1);
    end
    if (disturb != 0) begin
      early = 0;
      repeat (20) begin
        @(negedge clk);
        if (!in_ready || !txd) early = 1;
      end
      check("R2", "busy word not sent", early, 0);
    end
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    int pe, ev, st;
    repeat (4) @(negedge clk);
    check("R1", "reset txd", txd, 1);
    check("R1", "reset ready", in_ready, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h96;
    for (int wl = 5; wl <= 8; wl++)
      for (int ts = 0; ts < 2; ts++)
        for (int pm = 0; pm < 5; pm++) begin
          pe = (pm != 0); ev = (pm == 2 || pm == 4); st = (pm >= 3);
          pats[3] = 8'($urandom);
          for (int p = 0; p < 4; p++)
            send_frame(pats[p], wl, ts, pe, ev, st, 0, -1);
        end

    tick_period = 3;
    send_frame(8'hC5, 8, 1, 1, 0, 0, 0, -1);
    send_frame(8'h3A, 6, 0, 1, 1, 0, 0, -1);
    send_frame(8'h5B, 7, 1, 0, 0, 0, 1, -1);
    send_frame(8'h81, 8, 0, 1, 1, 0, 0, 3);
    tick_period = 1;
    send_frame(8'hE7, 5, 1, 1, 0, 1, 1, -1);
    send_frame(8'h4D, 8, 1, 1, 0, 0, 0, 5);

    // reset in the middle of a frame
    @(negedge clk);
    in_data = 8'h00; cfg_wlen = 2'd3; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "mid-frame reset txd", txd, 1);
    check("R1", "mid-frame reset ready", in_ready, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    send_frame(8'hA5, 8, 0, 1, 1, 0, 0, -1);

    summary();
    $finish;
  end
endmodule